// File: doc/BRIEF.md
# Register Access Command Parser

This block accepts a stream of bytes holding bracketed text commands and turns each complete command into one transaction on a simple register bus. A write command carries a three-byte address and a 16-bit value. A read command carries a three-byte address. For a read, the block samples the bus read data and sends back a bracketed response on an outgoing byte stream that uses a valid/ready handshake.

The top address byte chooses one of three register files, and each has its own select line. The two lower address bytes are driven onto the bus as the register offset. The parser starts again whenever it sees an opening brace in a framing position. It drops any command that breaks the framing, and it performs no bus access until the closing brace of a command arrives.

The block sits between a serial receiver or transmitter and a set of register files. It does not include the serial link or the register storage.

Top module: `reg_cmd_parser`

## Requirements
- R1: A write command is the byte sequence `{` `W` `<` A2 A1 A0 `>` `,` `V` `<` 0x00 DH DL `>` `}`. When the write maps to a region, the block drives `bus_wr_stb` high for exactly one cycle after the closing brace is accepted. In that cycle `bus_addr` = {A1,A0} and `bus_wdata` = {DH,DL}.
- R2: A read command is `{` `R` `<` A2 A1 A0 `>` `}`. When the read maps to a region, the block drives `bus_rd_stb` high for exactly one cycle with `bus_addr` = {A1,A0}. It then sends the 8-byte response `{` `V` `<` 0x00 H L `>` `}`, where H:L is the `bus_rdata` value sampled during the strobe cycle, high byte first.
- R3: The region select is one-hot on `bus_sel`. A2 = 0x03 sets bit 0 (system file), A2 = 0x04 sets bit 1 (image file) and A2 = 0x05 sets bit 2 (FIFO file).
- R4: If A2 matches no region, a write causes no strobe. A read causes no strobe and its response carries the value 0x0000.
- R5: No strobe occurs unless the final byte is `}`. A command whose last byte is anything else causes no bus access.
- R6: Any unexpected byte in a framing position (for example a wrong command letter or a missing `<`) drops the command without a bus access. The next well-formed command is then executed normally.
- R7: `{` (0x7B) received in any framing position restarts parsing at the command letter. Address and value bytes are taken as raw data even when they equal 0x7B or 0x7D.
- R8: A write whose padding byte is not 0x00 is discarded, and no strobe occurs.
- R9: While a response is pending, `in_ready` is low and no input byte is accepted. A response byte that is not taken holds `out_valid` high and keeps `out_data` unchanged until `out_ready` is high.
- R10: After reset, `bus_wr_stb`, `bus_rd_stb` and `out_valid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming byte present |
| in_data | input | 8 | Incoming byte |
| in_ready | output | 1 | Parser can accept a byte |
| bus_sel | output | 3 | One-hot register-file select |
| bus_addr | output | 16 | Register offset (A1,A0) |
| bus_wdata | output | 16 | Write value |
| bus_wr_stb | output | 1 | Single-cycle write strobe |
| bus_rd_stb | output | 1 | Single-cycle read strobe |
| bus_rdata | input | 16 | Read data, sampled during the read strobe |
| out_valid | output | 1 | Response byte present |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Consumer takes the response byte |

## Verification
The bench sends commands whose address and value bytes equal the brace codes. A parser that restarted inside the payload would lose those commands or strobe with a shifted offset. It also sends commands with a wrong closing byte, a non-zero padding byte and a bad tag. A design that acted before the closing brace, or that ignored the padding byte, would raise a strobe on these, and the bench watches for such a strobe. Reads of unmapped regions must return zeros without a strobe, so a design that leaked the bus data into that response is caught. Random back-pressure on the response checks that bytes are held stable and that input is blocked while a response is pending.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
   localparam logic [7:0] CH_OPEN  = 8'h7B;
   localparam logic [7:0] CH_CLOSE = 8'h7D;
   localparam logic [7:0] CH_LT    = 8'h3C;
   localparam logic [7:0] CH_GT    = 8'h3E;
   localparam logic [7:0] CH_COMMA = 8'h2C;
   localparam logic [7:0] CH_WR    = 8'h57;
   localparam logic [7:0] CH_RD    = 8'h52;
   localparam logic [7:0] CH_VAL   = 8'h56;
   localparam logic [7:0] CH_PAD   = 8'h00;

   typedef enum logic [3:0] {
      PS_IDLE, PS_KIND, PS_ALT, PS_ADDR, PS_AGT, PS_COMMA,
      PS_VTAG, PS_VLT, PS_PAD, PS_DATA, PS_VGT, PS_END
   } pstate_e;
endpackage

// File: rtl/cmdp_region_dec.sv
module cmdp_region_dec #(
   parameter int N_REGIONS = 3,
   parameter logic [N_REGIONS*8-1:0] REGION_TAGS = {8'h05, 8'h04, 8'h03}
) (
   input  logic [7:0]           tag,
   output logic [N_REGIONS-1:0] sel,
   output logic                 hit
);
   generate
      if (N_REGIONS < 1) begin : g_bad_n
         $error("cmdp_region_dec: N_REGIONS must be at least 1");
      end
      for (genvar i = 0; i < N_REGIONS; i++) begin : g_cmp
         for (genvar j = i + 1; j < N_REGIONS; j++) begin : g_uniq
            if (REGION_TAGS[i*8 +: 8] == REGION_TAGS[j*8 +: 8]) begin : g_dup
               $error("cmdp_region_dec: region tags must be distinct");
            end
         end
         assign sel[i] = (tag == REGION_TAGS[i*8 +: 8]);
      end
   endgenerate

   assign hit = |sel;
endmodule

// File: rtl/cmdp_parser.sv
module cmdp_parser
   import cmdp_pkg::*;
#(
   parameter int ADDR_BYTES = 3,
   parameter int DATA_BYTES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_ready,
   input  logic [7:0]              in_data,
   output logic                    fire,
   output logic                    is_wr,
   output logic [ADDR_BYTES*8-1:0] cmd_addr,
   output logic [DATA_BYTES*8-1:0] cmd_wdata
);
   localparam int AW    = ADDR_BYTES * 8;
   localparam int DW    = DATA_BYTES * 8;
   localparam int MAXB  = (ADDR_BYTES > DATA_BYTES) ? ADDR_BYTES : DATA_BYTES;
   localparam int CNT_W = $clog2(MAXB + 1);

   generate
      if (ADDR_BYTES < 2) begin : g_bad_a
         $error("cmdp_parser: ADDR_BYTES must be at least 2");
      end
      if (DATA_BYTES < 1) begin : g_bad_d
         $error("cmdp_parser: DATA_BYTES must be at least 1");
      end
   endgenerate

   pstate_e          state, nxt, fail_st;
   logic [CNT_W-1:0] cnt;
   logic             take_addr, take_data, done;
   logic             acc;

   assign acc     = in_valid && in_ready;
   assign fail_st = (in_data == CH_OPEN) ? PS_KIND : PS_IDLE;

   always_comb begin
      nxt       = state;
      take_addr = 1'b0;
      take_data = 1'b0;
      done      = 1'b0;
      unique case (state)
         PS_IDLE:  nxt = (in_data == CH_OPEN) ? PS_KIND : PS_IDLE;
         PS_KIND:  nxt = (in_data == CH_WR || in_data == CH_RD) ? PS_ALT : fail_st;
         PS_ALT:   nxt = (in_data == CH_LT) ? PS_ADDR : fail_st;
         PS_ADDR: begin
            take_addr = 1'b1;
            nxt = (cnt == CNT_W'(ADDR_BYTES - 1)) ? PS_AGT : PS_ADDR;
         end
         PS_AGT:   nxt = (in_data == CH_GT) ? (is_wr ? PS_COMMA : PS_END) : fail_st;
         PS_COMMA: nxt = (in_data == CH_COMMA) ? PS_VTAG : fail_st;
         PS_VTAG:  nxt = (in_data == CH_VAL) ? PS_VLT : fail_st;
         PS_VLT:   nxt = (in_data == CH_LT) ? PS_PAD : fail_st;
         PS_PAD:   nxt = (in_data == CH_PAD) ? PS_DATA : fail_st;
         PS_DATA: begin
            take_data = 1'b1;
            nxt = (cnt == CNT_W'(DATA_BYTES - 1)) ? PS_VGT : PS_DATA;
         end
         PS_VGT:   nxt = (in_data == CH_GT) ? PS_END : fail_st;
         PS_END: begin
            done = (in_data == CH_CLOSE);
            nxt  = (in_data == CH_CLOSE) ? PS_IDLE : fail_st;
         end
         default:  nxt = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= PS_IDLE;
         cnt       <= '0;
         fire      <= 1'b0;
         is_wr     <= 1'b0;
         cmd_addr  <= '0;
         cmd_wdata <= '0;
      end else begin
         fire <= 1'b0;
         if (acc) begin
            state <= nxt;
            fire  <= done;
            cnt   <= (take_addr || take_data) ? cnt + 1'b1 : '0;
            if (state == PS_KIND) is_wr <= (in_data == CH_WR);
            if (take_addr) cmd_addr <= {cmd_addr[AW-9:0], in_data};
            if (take_data) cmd_wdata <= {cmd_wdata[DW-9:0], in_data};
         end
      end
   end

   // R5: a command executes only right after an accepted closing brace
   assert_exec_after_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> $past(acc && in_data == CH_CLOSE));

   // R9: nothing is consumed while input is blocked
   assert_no_take_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> $stable(state));
endmodule

// File: rtl/cmdp_rsp_gen.sv
module cmdp_rsp_gen
   import cmdp_pkg::*;
#(
   parameter int DATA_BYTES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [DATA_BYTES*8-1:0] load_data,
   input  logic                    out_ready,
   output logic                    out_valid,
   output logic [7:0]              out_data
);
   localparam int DW      = DATA_BYTES * 8;
   localparam int RSP_LEN = DATA_BYTES + 6;
   localparam int IDX_W   = $clog2(RSP_LEN);

   logic [IDX_W-1:0] idx;
   logic [DW-1:0]    held;
   logic [DW-1:0]    shifted;
   logic [31:0]      k;

   always_comb begin
      k       = 32'(idx) - 32'd4;
      shifted = held << (k * 8);
      if (idx == IDX_W'(0))                    out_data = CH_OPEN;
      else if (idx == IDX_W'(1))               out_data = CH_VAL;
      else if (idx == IDX_W'(2))               out_data = CH_LT;
      else if (idx == IDX_W'(3))               out_data = CH_PAD;
      else if (32'(idx) < 32'(DATA_BYTES + 4)) out_data = shifted[DW-1 -: 8];
      else if (32'(idx) == 32'(DATA_BYTES + 4)) out_data = CH_GT;
      else                                     out_data = CH_CLOSE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         idx       <= '0;
         held      <= '0;
      end else if (!out_valid) begin
         if (load) begin
            out_valid <= 1'b1;
            idx       <= '0;
            held      <= load_data;
         end
      end else if (out_ready) begin
         if (idx == IDX_W'(RSP_LEN - 1)) begin
            out_valid <= 1'b0;
            idx       <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   // R9: a stalled byte stays put
   assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R2: every response starts with an opening brace
   assert_rsp_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (out_data == CH_OPEN));
endmodule

// File: rtl/reg_cmd_parser.sv
module reg_cmd_parser #(
   parameter int ADDR_BYTES = 3,
   parameter int DATA_BYTES = 2,
   parameter int N_REGIONS  = 3,
   parameter logic [N_REGIONS*8-1:0] REGION_TAGS = {8'h05, 8'h04, 8'h03}
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [7:0]                    in_data,
   output logic                          in_ready,
   output logic [N_REGIONS-1:0]          bus_sel,
   output logic [(ADDR_BYTES-1)*8-1:0]   bus_addr,
   output logic [DATA_BYTES*8-1:0]       bus_wdata,
   output logic                          bus_wr_stb,
   output logic                          bus_rd_stb,
   input  logic [DATA_BYTES*8-1:0]       bus_rdata,
   output logic                          out_valid,
   output logic [7:0]                    out_data,
   input  logic                          out_ready
);
   localparam int AW = ADDR_BYTES * 8;
   localparam int DW = DATA_BYTES * 8;

   logic          fire, is_wr, hit;
   logic [AW-1:0] cmd_addr;
   logic [DW-1:0] rsp_word;

   assign in_ready = !out_valid;

   cmdp_parser #(.ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES)) parse_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .fire(fire), .is_wr(is_wr),
      .cmd_addr(cmd_addr), .cmd_wdata(bus_wdata)
   );

   cmdp_region_dec #(.N_REGIONS(N_REGIONS), .REGION_TAGS(REGION_TAGS)) dec_i (
      .tag(cmd_addr[AW-1 -: 8]), .sel(bus_sel), .hit(hit)
   );

   assign bus_addr   = cmd_addr[AW-9:0];
   assign bus_wr_stb = fire && is_wr && hit;
   assign bus_rd_stb = fire && !is_wr && hit;
   assign rsp_word   = hit ? bus_rdata : '0;

   cmdp_rsp_gen #(.DATA_BYTES(DATA_BYTES)) rsp_i (
      .clk(clk), .rst_n(rst_n), .load(fire && !is_wr), .load_data(rsp_word),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
   );

   // R1: write strobe lasts one cycle
   assert_wr_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_stb |=> !bus_wr_stb);

   // R2: read strobe lasts one cycle and is followed by a response
   assert_rd_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_stb |=> (!bus_rd_stb && out_valid));

   // R3: a strobe always carries exactly one region select
   assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_stb || bus_rd_stb) |-> $onehot(bus_sel));

   // R1: the two strobes never coincide
   assert_stb_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr_stb && bus_rd_stb));
endmodule

// File: tb/reg_cmd_parser_tb_top.sv
module reg_cmd_parser_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_ready;
   logic [2:0]  bus_sel;
   logic [15:0] bus_addr, bus_wdata, bus_rdata;
   logic        bus_wr_stb, bus_rd_stb;
   logic        out_valid;
   logic [7:0]  out_data;
   logic        out_ready = 1'b1;

   int total = 0, bad = 0;
   int wr_cnt, rd_cnt, rsp_n;
   logic [2:0]  c_sel, r_sel;
   logic [15:0] c_addr, c_wdata, r_addr;
   logic [63:0] rsp_acc;
   bit          stall_mode = 0, prev_stall = 0, mon_on = 0, finished = 0;
   logic [7:0]  prev_data;
   logic [7:0]  sbuf[0:31];
   int          nbuf;

   always #2 clk = ~clk;

   reg_cmd_parser dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .bus_sel(bus_sel), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_wr_stb(bus_wr_stb), .bus_rd_stb(bus_rd_stb),
      .bus_rdata(bus_rdata), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready)
   );

   function automatic logic [15:0] rd_model(input logic [2:0] s, input logic [15:0] a);
      return a ^ {s, 13'h0A5};
   endfunction
   assign bus_rdata = rd_model(bus_sel, bus_addr);

   function automatic logic [2:0] exp_sel(input logic [7:0] a2);
      case (a2)
         8'h03: return 3'b001;
         8'h04: return 3'b010;
         8'h05: return 3'b100;
         default: return 3'b000;
      endcase
   endfunction

   function automatic logic [63:0] exp_rsp(input logic [15:0] d);
      return {8'h7B, 8'h56, 8'h3C, 8'h00, d[15:8], d[7:0], 8'h3E, 8'h7D};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (mon_on) begin
         out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
         if (prev_stall) chk(out_valid && out_data == prev_data, "R9 stall hold", {56'h0, out_data}, {56'h0, prev_data});
         if (out_valid && in_ready) chk(0, "R9 in_ready low while pending", 1, 0);
         if (bus_wr_stb) begin wr_cnt++; c_sel = bus_sel; c_addr = bus_addr; c_wdata = bus_wdata; end
         if (bus_rd_stb) begin rd_cnt++; r_sel = bus_sel; r_addr = bus_addr; end
         if (out_valid && out_ready) begin rsp_acc = {rsp_acc[55:0], out_data}; rsp_n++; end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
      end
   end

   task automatic clr();
      wr_cnt = 0; rd_cnt = 0; rsp_n = 0; rsp_acc = '0; nbuf = 0;
   endtask

   task automatic push(input logic [7:0] b);
      sbuf[nbuf] = b; nbuf++;
   endtask

   task automatic send_buf();
      for (int i = 0; i < nbuf; i++) begin
         while (!in_ready) @(negedge clk);
         in_valid = 1'b1; in_data = sbuf[i];
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic settle(input int want_rsp);
      int n = 0;
      repeat (3) @(negedge clk);
      while (rsp_n < want_rsp && n < 300) begin @(negedge clk); n++; end
      repeat (3) @(negedge clk);
   endtask

   task automatic build_wr(input logic [7:0] a2, a1, a0, dh, dl, pad, close);
      push(8'h7B); push(8'h57); push(8'h3C); push(a2); push(a1); push(a0);
      push(8'h3E); push(8'h2C); push(8'h56); push(8'h3C); push(pad);
      push(dh); push(dl); push(8'h3E); push(close);
   endtask

   task automatic build_rd(input logic [7:0] a2, a1, a0);
      push(8'h7B); push(8'h52); push(8'h3C); push(a2); push(a1); push(a0);
      push(8'h3E); push(8'h7D);
   endtask

   task automatic do_wr(input logic [7:0] a2, a1, a0, dh, dl, input string req);
      logic [2:0] es = exp_sel(a2);
      clr(); build_wr(a2, a1, a0, dh, dl, 8'h00, 8'h7D); send_buf(); settle(0);
      if (es != 3'b000) begin
         chk(wr_cnt == 1 && rd_cnt == 0, {req, " write strobe count"}, wr_cnt, 1);
         chk(c_sel == es, {req, " R3 select"}, c_sel, es);
         chk(c_addr == {a1, a0} && c_wdata == {dh, dl}, {req, " R1 addr/data"},
             {c_addr, c_wdata}, {a1, a0, dh, dl});
      end else begin
         chk(wr_cnt == 0 && rd_cnt == 0, {req, " R4 no strobe"}, wr_cnt, 0);
      end
   endtask

   task automatic do_rd(input logic [7:0] a2, a1, a0, input string req);
      logic [2:0] es = exp_sel(a2);
      logic [15:0] ed = (es != 3'b000) ? rd_model(es, {a1, a0}) : 16'h0000;
      clr(); build_rd(a2, a1, a0); send_buf(); settle(8);
      chk(rd_cnt == ((es != 3'b000) ? 1 : 0) && wr_cnt == 0, {req, " R2/R4 read strobe count"}, rd_cnt, (es != 3'b000));
      if (es != 3'b000) chk(r_sel == es && r_addr == {a1, a0}, {req, " R3 read select/addr"}, {r_sel, r_addr}, {es, a1, a0});
      chk(rsp_n == 8 && rsp_acc == exp_rsp(ed), {req, " R2 response"}, rsp_acc, exp_rsp(ed));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(!bus_wr_stb && !bus_rd_stb && !out_valid && in_ready, "R10 reset state",
          {bus_wr_stb, bus_rd_stb, out_valid, in_ready}, 4'b0001);
      mon_on = 1;

      do_wr(8'h03, 8'h12, 8'h34, 8'hAB, 8'hCD, "R1 sys");
      do_rd(8'h04, 8'h00, 8'h10, "R2 img");
      do_wr(8'h05, 8'hFF, 8'h01, 8'h00, 8'h00, "R3 fifo");
      do_rd(8'h03, 8'hA0, 8'h0B, "R3 sys read");
      do_wr(8'h06, 8'h00, 8'h01, 8'h11, 8'h22, "R4 unmapped");
      do_rd(8'h02, 8'h55, 8'h66, "R4 unmapped");

      // R5 wrong closing byte
      clr(); build_wr(8'h03, 8'h01, 8'h02, 8'h03, 8'h04, 8'h00, 8'h58); send_buf(); settle(0);
      chk(wr_cnt == 0, "R5 no access without close", wr_cnt, 0);

      // R6 bad command letter and missing '<'
      clr(); push(8'h7B); push(8'h51); push(8'h3C); push(8'h03); push(8'h00); push(8'h00);
      push(8'h3E); push(8'h7D); send_buf(); settle(0);
      chk(wr_cnt == 0 && rd_cnt == 0 && rsp_n == 0, "R6 bad letter dropped", rd_cnt + wr_cnt, 0);
      clr(); push(8'h7B); push(8'h52); push(8'h3D); push(8'h04); push(8'h00); push(8'h00);
      push(8'h3E); push(8'h7D); send_buf(); settle(0);
      chk(rd_cnt == 0 && rsp_n == 0, "R6 missing lt dropped", rsp_n, 0);
      do_rd(8'h05, 8'h00, 8'h02, "R6 recovery");

      // R7 restart on '{' in a framing slot
      clr(); push(8'h7B); push(8'h57); push(8'h3C); push(8'h03); push(8'h00); push(8'h00); push(8'h3E);
      build_wr(8'h04, 8'h22, 8'h33, 8'h44, 8'h55, 8'h00, 8'h7D); send_buf(); settle(0);
      chk(wr_cnt == 1 && c_sel == 3'b010 && c_addr == 16'h2233 && c_wdata == 16'h4455,
          "R7 restart on open brace", {wr_cnt[15:0], c_addr, c_wdata}, {16'd1, 16'h2233, 16'h4455});
      // R7 brace codes as payload
      do_wr(8'h03, 8'h7B, 8'h7D, 8'h7B, 8'h7D, "R7 payload braces");

      // R8 non-zero padding byte
      clr(); build_wr(8'h05, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'h7D); send_buf(); settle(0);
      chk(wr_cnt == 0, "R8 pad byte nonzero", wr_cnt, 0);

      // R9 back-pressure on response, then random mix
      stall_mode = 1;
      do_rd(8'h04, 8'hBE, 8'hEF, "R9 stalled read");
      for (int n = 0; n < 40; n++) begin
         logic [7:0] a2 = (($urandom % 5) == 0) ? 8'($urandom) : 8'(3 + ($urandom % 3));
         if ($urandom % 2) do_wr(a2, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "R1 random");
         else              do_rd(a2, 8'($urandom), 8'($urandom), "R2 random");
      end
      stall_mode = 0;
      repeat (4) @(negedge clk);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule